// File: doc/BRIEF.md
# Lamp Ballast Mode and Fault Sequencer

This block is the digital supervisor of a lamp ballast controller. Analog comparators outside it turn the supply, the rectified bus, the half-bridge current-sense resistor, the end-of-life window and the shutdown pin into one-bit flags. A timing ramp adds one more flag that says preheat is complete, and the oscillator gives one strobe per half-bridge period. The sequencer reads these flags and decides the operating mode. It also drives the three gate-enable lines: the high-side switch, the low-side switch and the power-factor stage. A fourth line asks for the preheat timing capacitor to be discharged.

The modes run in this order: lockout, preheat, ignition, run. Repeated over-current across consecutive switching periods, in ignition or in run, causes a latched fault. An end-of-life window violation also causes a latched fault, but only while in run. A fault is cleared only by a route back through lockout, caused by a low supply or by the shutdown flag. Every flag passes through a two-stage synchroniser. The strobe and the current-sense flag pass through matching stages, so each period is sampled exactly once. All pins are plain level or pulse signals and carry no flow control, so no valid/ready handshake applies.

Top module: `ballast_seq`

## Requirements
- R1: While reset is asserted, and in lockout, `mode_o` is 0, all three gate enables are low and `cph_dis_o` is high. The mode codes are 0 lockout, 1 preheat, 2 ignition, 3 run and 4 fault.
- R2: Lockout moves to preheat only when `vcc_low_i`, `bus_low_i` and `sd_hi_i` are all low.
- R3: Preheat moves to ignition when `ramp_done_i` is high. In preheat, ignition and run, all three gate enables are high and `cph_dis_o` is low.
- R4: Ignition moves to run on the `IGN_CYCLES`-th strobe (default 8) counted in ignition. After fewer strobes the block stays in ignition.
- R5: Over-current is sampled only on a strobe and only in ignition or run, and adds to a count of consecutive events. A strobe with `oc_hit_i` low clears the count. The count carries across the move from ignition to run, and strobes in preheat are not counted.
- R6: The block enters fault when the consecutive count exceeds `OC_LIMIT` (default 50), so on the 51st consecutive over-current strobe. After 50 it stays where it is.
- R7: In run, `eol_hi_i` or `eol_lo_i` high forces fault. In preheat the same flags have no effect.
- R8: In fault, all gate enables are low and `cph_dis_o` is high.
- R9: Fault is left only by `vcc_low_i` or `sd_hi_i` going high, and both lead to lockout. `bus_low_i` and the end-of-life flags do not release a fault.
- R10: In preheat, ignition or run, any of `vcc_low_i`, `bus_low_i` or `sd_hi_i` high returns the block to lockout with the gates off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_low_i | input | 1 | Supply below its turn-off threshold |
| bus_low_i | input | 1 | DC bus below its undervoltage threshold |
| sd_hi_i | input | 1 | Shutdown pin above its threshold |
| eol_hi_i | input | 1 | End-of-life sense above the upper window |
| eol_lo_i | input | 1 | End-of-life sense below the lower window |
| ramp_done_i | input | 1 | Preheat ramp complete |
| oc_hit_i | input | 1 | Current sense over its threshold in this period |
| cyc_stb_i | input | 1 | One-clock pulse per half-bridge period |
| mode_o | output | 3 | Current mode code |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |
| pfc_en_o | output | 1 | Power-factor gate enable |
| cph_dis_o | output | 1 | Preheat capacitor discharge request |

## Verification
The hardest case to reach is the exact fault boundary of the consecutive over-current count. The count cannot be seen at the ports, so its value has to be inferred from the mode. The stimulus sends 50 over-current strobes, then one clean strobe, then 50 more, and checks that the block is still in run. One further strobe must then cause a fault. A second run starts the streak during ignition and lets the move to run happen partway through the streak, which shows that the count carries across the two modes.

// File: rtl/ballast_pkg.sv
package ballast_pkg;
  typedef enum logic [2:0] {
    M_LOCK = 3'd0,
    M_PRE  = 3'd1,
    M_IGN  = 3'd2,
    M_RUN  = 3'd3,
    M_FLT  = 3'd4
  } mode_e;
endpackage

// File: rtl/ballast_sync.sv
module ballast_sync #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= RST_VAL[g];
        s2_q <= RST_VAL[g];
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/ballast_oc_count.sv
module ballast_oc_count #(
  parameter int OC_LIMIT = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic stb_i,
  input  logic oc_i,
  output logic trip_o
);
  localparam int CW = $clog2(OC_LIMIT + 2);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};
  localparam logic [CW-1:0] LIM  = CW'(OC_LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!active_i) begin
      cnt_q <= '0;
    end else if (stb_i) begin
      if (!oc_i)              cnt_q <= '0;
      else if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign trip_o = (cnt_q > LIM);

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && stb_i && oc_i) |=> (cnt_q >= $past(cnt_q))) else $error("count wrapped"); // R5
endmodule

// File: rtl/ballast_fsm.sv
module ballast_fsm
  import ballast_pkg::*;
#(
  parameter int IGN_CYCLES = 8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  vcc_low_i,
  input  logic  bus_low_i,
  input  logic  sd_hi_i,
  input  logic  eol_hi_i,
  input  logic  eol_lo_i,
  input  logic  ramp_i,
  input  logic  stb_i,
  input  logic  trip_i,
  output mode_e mode_o,
  output logic  oc_active_o,
  output logic  gate_en_o,
  output logic  cph_dis_o
);
  localparam int IW = $clog2(IGN_CYCLES + 1);
  localparam logic [IW-1:0] IGN_LAST = IW'(IGN_CYCLES - 1);

  mode_e st_q, nxt;
  logic [IW-1:0] ign_q;
  logic go_lock;

  assign go_lock = vcc_low_i | bus_low_i | sd_hi_i;

  always_comb begin
    nxt = st_q;
    unique case (st_q)
      M_LOCK: if (!go_lock) nxt = M_PRE;
      M_PRE: begin
        if (go_lock)     nxt = M_LOCK;
        else if (ramp_i) nxt = M_IGN;
      end
      M_IGN: begin
        if (go_lock)                         nxt = M_LOCK;
        else if (trip_i)                     nxt = M_FLT;
        else if (stb_i && ign_q == IGN_LAST) nxt = M_RUN;
      end
      M_RUN: begin
        if (go_lock)                     nxt = M_LOCK;
        else if (trip_i)                 nxt = M_FLT;
        else if (eol_hi_i || eol_lo_i)   nxt = M_FLT;
      end
      M_FLT: if (vcc_low_i || sd_hi_i) nxt = M_LOCK;
      default: nxt = M_LOCK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= M_LOCK;
      ign_q <= '0;
    end else begin
      st_q <= nxt;
      if (st_q != M_IGN)  ign_q <= '0;
      else if (stb_i)     ign_q <= ign_q + 1'b1;
    end
  end

  assign mode_o      = st_q;
  assign oc_active_o = (st_q == M_IGN) || (st_q == M_RUN);
  assign gate_en_o   = (st_q == M_PRE) || (st_q == M_IGN) || (st_q == M_RUN);
  assign cph_dis_o   = (st_q == M_LOCK) || (st_q == M_FLT);

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == M_FLT && !vcc_low_i && !sd_hi_i) |=> (st_q == M_FLT)) else $error("fault released"); // R9
  AST_RUN_FROM_IGN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == M_RUN && $past(st_q) != M_RUN) |-> ($past(st_q) == M_IGN)) else $error("bad run entry"); // R4
  AST_LOCK_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == M_LOCK && st_q != M_LOCK) |-> (st_q == M_PRE)) else $error("bad lock exit"); // R2
  AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == M_FLT && $past(st_q) != M_FLT) |->
      ($past(trip_i) || ($past(st_q) == M_RUN && $past(eol_hi_i || eol_lo_i)))) else $error("bad fault entry"); // R7
endmodule

// File: rtl/ballast_seq.sv
module ballast_seq
  import ballast_pkg::*;
#(
  parameter int OC_LIMIT   = 50,
  parameter int IGN_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vcc_low_i,
  input  logic       bus_low_i,
  input  logic       sd_hi_i,
  input  logic       eol_hi_i,
  input  logic       eol_lo_i,
  input  logic       ramp_done_i,
  input  logic       oc_hit_i,
  input  logic       cyc_stb_i,
  output logic [2:0] mode_o,
  output logic       hs_en_o,
  output logic       ls_en_o,
  output logic       pfc_en_o,
  output logic       cph_dis_o
);
  localparam int NF = 8;

  logic [NF-1:0] raw, syn;
  logic trip, oc_active, gate_en;
  mode_e mode;

  assign raw = {cyc_stb_i, oc_hit_i, ramp_done_i, eol_lo_i,
                eol_hi_i, sd_hi_i, bus_low_i, vcc_low_i};

  ballast_sync #(.W(NF), .RST_VAL(NF'(1))) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(syn)
  );

  ballast_oc_count #(.OC_LIMIT(OC_LIMIT)) u_oc (
    .clk(clk), .rst_n(rst_n), .active_i(oc_active),
    .stb_i(syn[7]), .oc_i(syn[6]), .trip_o(trip)
  );

  ballast_fsm #(.IGN_CYCLES(IGN_CYCLES)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .vcc_low_i(syn[0]), .bus_low_i(syn[1]), .sd_hi_i(syn[2]),
    .eol_hi_i(syn[3]), .eol_lo_i(syn[4]), .ramp_i(syn[5]),
    .stb_i(syn[7]), .trip_i(trip),
    .mode_o(mode), .oc_active_o(oc_active),
    .gate_en_o(gate_en), .cph_dis_o(cph_dis_o)
  );

  assign mode_o   = mode;
  assign hs_en_o  = gate_en;
  assign ls_en_o  = gate_en;
  assign pfc_en_o = gate_en;

  AST_FAULT_GATES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd4) |-> (!hs_en_o && !ls_en_o && !pfc_en_o && cph_dis_o)) else $error("gates on in fault"); // R8
endmodule

// File: tb/ballast_seq_tb_top.sv
`timescale 1ns/1ps
module ballast_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vcc_low = 1'b1, bus_low = 1'b0, sd_hi = 1'b0, eol_hi = 1'b0, eol_lo = 1'b0;
  logic ramp = 1'b0, oc = 1'b0, stb = 1'b0;
  logic [2:0] mode;
  logic hs, ls, pfc, cph;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ballast_seq dut_i (
    .clk(clk), .rst_n(rst_n), .vcc_low_i(vcc_low), .bus_low_i(bus_low),
    .sd_hi_i(sd_hi), .eol_hi_i(eol_hi), .eol_lo_i(eol_lo), .ramp_done_i(ramp),
    .oc_hit_i(oc), .cyc_stb_i(stb), .mode_o(mode), .hs_en_o(hs), .ls_en_o(ls),
    .pfc_en_o(pfc), .cph_dis_o(cph)
  );

  // fields: vcc bus sd eolhi eollo ramp | strobes(7) | mode(3) | gates on
  localparam int NV = 17;
  localparam logic [NV-1:0][16:0] VEC = '{
    {6'b100000, 7'd0, 3'd0, 1'b0},  // R1 supply low holds lockout
    {6'b000000, 7'd0, 3'd1, 1'b1},  // R2 flags clear, preheat
    {6'b000100, 7'd0, 3'd1, 1'b1},  // R7 eol ignored in preheat
    {6'b000001, 7'd0, 3'd2, 1'b1},  // R3 ramp done, ignition
    {6'b000001, 7'd7, 3'd2, 1'b1},  // R4 seven strobes not enough
    {6'b000001, 7'd1, 3'd3, 1'b1},  // R4 eighth strobe, run
    {6'b000011, 7'd0, 3'd4, 1'b0},  // R7 eol low in run, fault
    {6'b010001, 7'd0, 3'd4, 1'b0},  // R9 bus low ignored in fault
    {6'b000001, 7'd0, 3'd4, 1'b0},  // R9 fault held with flags clear
    {6'b001001, 7'd0, 3'd0, 1'b0},  // R9 shutdown releases to lockout
    {6'b000001, 7'd0, 3'd2, 1'b1},  // R2 restart through to ignition
    {6'b010001, 7'd0, 3'd0, 1'b0},  // R10 bus low in ignition
    {6'b000001, 7'd8, 3'd3, 1'b1},  // R4 full ignition count
    {6'b000101, 7'd0, 3'd4, 1'b0},  // R7 eol high in run
    {6'b100001, 7'd0, 3'd0, 1'b0},  // R9 supply low releases fault
    {6'b000000, 7'd0, 3'd1, 1'b1},  // R3 preheat waits for ramp
    {6'b001000, 7'd0, 3'd0, 1'b0}   // R10 shutdown in preheat
  };

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe(input int n, input logic with_oc);
    oc = with_oc;
    for (int i = 0; i < n; i++) begin
      stb = 1'b1;
      @(negedge clk);
      stb = 1'b0;
      wait_cyc(2);
    end
    oc = 1'b0;
  endtask

  task automatic check(input logic [2:0] em, input logic een, input string tag);
    n_chk++;
    if (mode !== em || hs !== een || ls !== een || pfc !== een || cph !== ~een) begin
      n_fail++;
      $display("FAIL %s: mode=%0d gates=%b%b%b cph=%b expected mode=%0d gates=%b cph=%b",
               tag, mode, hs, ls, pfc, cph, em, een, ~een);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    check(3'd0, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    wait_cyc(2);
    check(3'd0, 1'b0, "R1 after reset, supply low");

    for (int v = NV - 1; v >= 0; v--) begin
      {vcc_low, bus_low, sd_hi, eol_hi, eol_lo, ramp} = VEC[v][16:11];
      wait_cyc(6);
      strobe(int'(VEC[v][10:4]), 1'b0);
      wait_cyc(5);
      check(VEC[v][3:1], VEC[v][0], $sformatf("vector %0d", NV - 1 - v));
    end

    // R5 strobes with over-current in preheat are not counted
    {vcc_low, bus_low, sd_hi, eol_hi, eol_lo, ramp} = 6'b000000;
    wait_cyc(6);
    strobe(60, 1'b1);
    wait_cyc(5);
    check(3'd1, 1'b1, "R5 preheat ignores over-current");

    // R5/R6 consecutive streak broken by one clean period
    ramp = 1'b1;
    wait_cyc(6);
    strobe(8, 1'b0);
    wait_cyc(5);
    check(3'd3, 1'b1, "R4 run reached");
    strobe(50, 1'b1);
    strobe(1, 1'b0);
    strobe(50, 1'b1);
    wait_cyc(5);
    check(3'd3, 1'b1, "R5 clean period resets streak");
    strobe(1, 1'b1);
    wait_cyc(5);
    check(3'd4, 1'b0, "R6 51st consecutive faults");

    // R5 streak starts in ignition and carries into run
    vcc_low = 1'b1;
    wait_cyc(6);
    check(3'd0, 1'b0, "R9 supply low to lockout");
    vcc_low = 1'b0;
    wait_cyc(6);
    check(3'd2, 1'b1, "R2 back to ignition");
    strobe(8, 1'b1);
    wait_cyc(5);
    check(3'd3, 1'b1, "R4 run under over-current");
    strobe(42, 1'b1);
    wait_cyc(5);
    check(3'd3, 1'b1, "R6 fifty across modes holds");
    strobe(1, 1'b1);
    wait_cyc(5);
    check(3'd4, 1'b0, "R5 streak carried into run faults");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule